// File: doc/BRIEF.md
# Masked Interrupt Aggregation Register

This block gathers seven board-level interrupt lines (a real-time clock alarm, a temperature warning, a critical temperature alarm, two Ethernet PHY events and two USB overcurrent flags) into one 16-bit register. It also takes one interrupt source that software raises itself. Each hardware line passes through a two-flop synchronizer. The synchronized level appears in the low byte of the register as live status. Nothing needs to be cleared: a status bit drops when its source drops.

The high byte holds a mask bit for each source and the software interrupt bit. A mask bit of 1 blocks its source, and after reset every source is blocked. One registered output, `irq_out`, goes high when any source that is not masked is active, or when the software bit is set. Software reaches the register over a plain synchronous bus with address, read strobe, write strobe and 16-bit data. A read returns data on the cycle after the strobe. This is a control register, so the bus has no valid/ready handshake and never applies back-pressure. A strobe is taken on the same clock edge on which it is seen.

Top module: `irq_gather`

## Requirements
- R1: After reset, all seven mask bits (register bits 14:8) are 1, the software bit (bit 15) is 0, `irq_out` is 0 and `bus_rdata` is 0.
- R2: Register bits 6:0 show the level of `src_in[6:0]` two clock edges after the input changes, and they follow the input in both directions with no clear action.
- R3: Register bit 7 always reads 0.
- R4: A write to `REG_ADDR` loads bits 14:8 into the mask and bit 15 into the software bit. Data on bits 7:0 of a write has no effect on the status read back.
- R5: `irq_out` equals the OR over i of (status[i] AND NOT mask[i]), ORed with the software bit. It is registered, so it reflects status and mask one edge after they change.
- R6: When the software bit is 1, `irq_out` is 1 whatever the mask and status values are.
- R7: A write whose address is not `REG_ADDR` changes neither the mask nor the software bit.
- R8: `bus_rdata` holds the register word on the cycle after an edge that sees `bus_rd` high with `bus_addr == REG_ADDR`. After every other edge it holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register bus address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| src_in | input | 7 | Asynchronous interrupt source levels |
| irq_out | output | 1 | Combined interrupt, registered |

## Verification
The assertions check on every cycle that `irq_out` follows the masked OR of the previous cycle, that status trails the input by the synchronizer depth, that bit 7 reads 0, that reads return zero when not addressed, and that writes to other addresses leave the mask alone. Only the bench scenarios can show the end-to-end behaviour across ports. These are the full sweep of all 128 source patterns against varying masks, the sweep of all 128 mask values with every source active, the software bit overriding a full mask, and the fact that data written on the low byte never reaches the status.

// File: rtl/irqg_pkg.sv
package irqg_pkg;
  localparam int DATA_W   = 16;
  localparam int SRC_N    = 7;
  localparam int RSV_BIT  = 7;
  localparam int MASK_LSB = 8;
  localparam int SW_BIT   = 15;
endpackage

// File: rtl/irqg_sync.sv
module irqg_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= d_in;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/irqg_regs.sv
module irqg_regs
  import irqg_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [SRC_N-1:0]  status,
  output logic [SRC_N-1:0]  mask_q,
  output logic              sw_q,
  output logic [DATA_W-1:0] rdata_q
);
  logic              hit;
  logic [DATA_W-1:0] word;

  assign hit = (bus_addr == REG_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      sw_q   <= 1'b0;
    end else if (bus_wr && hit) begin
      mask_q <= bus_wdata[MASK_LSB +: SRC_N];
      sw_q   <= bus_wdata[SW_BIT];
    end
  end

  always_comb begin
    word                     = '0;
    word[SRC_N-1:0]          = status;
    word[MASK_LSB +: SRC_N]  = mask_q;
    word[SW_BIT]             = sw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rdata_q <= '0;
    else if (bus_rd && hit)  rdata_q <= word;
    else                     rdata_q <= '0;
  end
endmodule

// File: rtl/irqg_combine.sv
module irqg_combine #(
  parameter int WIDTH = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] status,
  input  logic [WIDTH-1:0] mask,
  input  logic             sw,
  output logic             irq_q
);
  logic [WIDTH-1:0] live;
  assign live = status & ~mask;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= (|live) | sw;
endmodule

// File: rtl/irq_gather.sv
module irq_gather
  import irqg_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h20,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  input  logic [6:0]        src_in,
  output logic              irq_out
);
  logic [SRC_N-1:0] status_w;
  logic [SRC_N-1:0] mask_w;
  logic             sw_w;

  irqg_sync #(.WIDTH(SRC_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(src_in), .d_out(status_w)
  );

  irqg_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .status(status_w),
    .mask_q(mask_w), .sw_q(sw_w), .rdata_q(bus_rdata)
  );

  irqg_combine #(.WIDTH(SRC_N)) u_comb (
    .clk(clk), .rst_n(rst_n), .status(status_w), .mask(mask_w),
    .sw(sw_w), .irq_q(irq_out)
  );
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk #(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h20,
  parameter int                SYNC_STAGES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [15:0]       bus_rdata,
  input logic [6:0]        src_in,
  input logic              irq_out,
  input logic [6:0]        status,
  input logic [6:0]        mask,
  input logic              sw
);
  logic [6:0] pipe [SYNC_STAGES];
  int unsigned since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= 0;
      for (int i = 0; i < SYNC_STAGES; i++) pipe[i] <= '0;
    end else begin
      if (since_rst < SYNC_STAGES + 1) since_rst <= since_rst + 1;
      pipe[0] <= src_in;
      for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  // R1
  mask_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask == 7'h7f && !sw && !irq_out));

  // R2
  status_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= SYNC_STAGES) |-> (status == pipe[SYNC_STAGES-1]));

  // R3
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[7] == 1'b0);

  // R5
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 1) |-> (irq_out == ((|($past(status) & ~$past(mask))) | $past(sw))));

  // R7
  foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_wr && bus_addr == REG_ADDR)) |=> ($stable(mask) && $stable(sw)));

  // R8
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_rd && bus_addr == REG_ADDR)) |=> (bus_rdata == 16'h0000));
endmodule

bind irq_gather irq_gather_chk #(
  .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_rdata(bus_rdata), .src_in(src_in),
  .irq_out(irq_out), .status(status_w), .mask(mask_w), .sw(sw_w)
);

// File: tb/irq_gather_bench.sv
module irq_gather_bench;
  localparam logic [7:0] RA = 8'h20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [6:0]  src_in = '0;
  logic        irq_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  irq_gather u_irq_gather (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src_in), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic logic exp_irq(input logic [6:0] s, input logic [6:0] m, input logic w);
    return (|(s & ~m)) | w;
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 irq", {15'h0, irq_out}, 16'h0);
    check("R1 rdata", bus_rdata, 16'h0);
    rst_n = 1'b1;
    bus_read(RA, rd);
    check("R1 word", rd, 16'h7f00);

    // R2 R3 R5: sweep all source patterns against a varying mask
    for (int p = 0; p < 128; p++) begin
      logic [6:0] m;
      m = 7'((p * 37 + 11) % 128);
      bus_write(RA, {1'b0, m, 8'h00});
      src_in = 7'(p);
      repeat (3) @(negedge clk);
      check("R5 irq sweep", {15'h0, irq_out}, {15'h0, exp_irq(7'(p), m, 1'b0)});
      bus_read(RA, rd);
      check("R2 status", {9'h0, rd[6:0]}, {9'h0, 7'(p)});
      check("R3 reserved", {15'h0, rd[7]}, 16'h0);
      check("R4 mask readback", {9'h0, rd[14:8]}, {9'h0, m});
    end

    // R5: all sources active, sweep every mask value; check one edge after write
    src_in = 7'h7f;
    repeat (3) @(negedge clk);
    for (int m = 0; m < 128; m++) begin
      bus_write(RA, {1'b0, 7'(m), 8'h00});
      @(negedge clk);
      check("R5 mask sweep", {15'h0, irq_out}, {15'h0, (m != 127)});
    end

    // R2: status falls with the source, no clear needed
    src_in = 7'h00;
    repeat (2) @(negedge clk);
    bus_read(RA, rd);
    check("R2 falls", {9'h0, rd[6:0]}, 16'h0);

    // R6 software bit with everything masked
    bus_write(RA, 16'hff00);
    @(negedge clk);
    check("R6 sw irq", {15'h0, irq_out}, 16'h1);
    bus_read(RA, rd);
    check("R6 sw readback", rd, 16'hff00);

    // R7 foreign address write ignored
    bus_write(8'h22, 16'h0000);
    bus_read(RA, rd);
    check("R7 foreign write", rd, 16'hff00);
    check("R7 irq held", {15'h0, irq_out}, 16'h1);

    // R4 low-byte write data ignored
    bus_write(RA, 16'h00ff);
    @(negedge clk);
    bus_read(RA, rd);
    check("R4 low byte ignored", rd, 16'h0000);
    check("R4 irq clear", {15'h0, irq_out}, 16'h0);

    // R8 foreign read returns zero
    bus_read(8'h21, rd);
    check("R8 foreign read", rd, 16'h0);
    @(negedge clk);
    check("R8 idle", bus_rdata, 16'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule